// File: doc/BRIEF.md
# Dual-Lane Burst Scratchpad

This block is the on-chip working store of a small matrix accelerator. It keeps five independent classes of operands (layer inputs, weights, bias terms, leak factors and post-activation results), each in its own directly addressable array of registers. Every class has two write lanes and two read lanes, so a pair of values can be stored and a pair fetched in each cycle, which matches the two rows or columns of the array that the buffer feeds.

Reads are issued as bursts. One single-cycle command carries a start address and a location count. From then on the class sequencer walks the array on its own and delivers two neighbouring locations per cycle until the count is spent. No further commands are needed. A new command may cut into a running burst, and a command with a count of zero stops it. Writes are plain: each write lane carries its own enable, address and value.

Class index encoding on the flattened ports: 0 inputs, 1 weights, 2 bias, 3 leak factors, 4 post-activation outputs. Class c occupies bits [c*W +: W] of each flattened bus of per-class width W.

Top module: `spad_burst_buffer`

## Requirements
- R1: In one cycle both write lanes of a class store their values at their own addresses, and a later burst returns both values.
- R2: If both write lanes of a class target the same address in the same cycle, lane B's value is the one kept.
- R3: A read command with count N>0 sampled at clock edge E0 delivers, at edge E0+1+k for k = 0 .. ceil(N/2)-1, location base+2k on lane A and base+2k+1 on lane B, each with its valid high. No further command is required.
- R4: For an odd N, in the final cycle of the burst lane A is valid and lane B has valid low and data 0. Lane B is never valid while lane A is not.
- R5: Busy rises the cycle after the command and stays high for exactly ceil(N/2) cycles. It is low in the cycle that shows the last pair. Valid is low in every cycle where no pair was scheduled.
- R6: A command arriving during a burst replaces it. The pair scheduled for that edge is still delivered, and the new burst's first pair follows in the next cycle with no gap.
- R7: A command with count 0 ends any running burst. Busy is low on the next cycle and no further pair follows the one already scheduled.
- R8: When a write and a burst read hit the same address at the same edge, the read returns the old value. The new value is returned by later reads.
- R9: Burst addresses wrap modulo the class depth (64 locations by default).
- R10: The classes are independent. Writes and bursts on one class leave the storage, valid and busy outputs of the other classes unchanged.
- R11: While reset is high, all valid and busy outputs go low and the read data goes to 0 at the next edge. Storage contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_a | input | N_CLASS | Write enable, lane A, one bit per class |
| wr_addr_a | input | N_CLASS*ADDR_W | Write address, lane A |
| wr_data_a | input | N_CLASS*DATA_W | Write value, lane A |
| wr_en_b | input | N_CLASS | Write enable, lane B (wins on equal address) |
| wr_addr_b | input | N_CLASS*ADDR_W | Write address, lane B |
| wr_data_b | input | N_CLASS*DATA_W | Write value, lane B |
| rd_go | input | N_CLASS | One-cycle burst command per class |
| rd_base | input | N_CLASS*ADDR_W | Burst start address |
| rd_len | input | N_CLASS*(ADDR_W+1) | Burst location count (0 cancels) |
| rd_data_a | output | N_CLASS*DATA_W | Lane A read value (even offset in burst) |
| rd_valid_a | output | N_CLASS | Lane A value valid |
| rd_data_b | output | N_CLASS*DATA_W | Lane B read value (odd offset in burst) |
| rd_valid_b | output | N_CLASS | Lane B value valid |
| busy | output | N_CLASS | Burst still has locations to schedule |

## Verification
The hardest situations to reach are those where a port event lands on the exact edge at which the sequencer schedules a pair. These are a write to the location being fetched, a replacing command, and a zero-count cancel. The bench drives inputs on the falling edge and counts edges from the command. It then places the write or the second command precisely one edge after the first pair was issued. It checks that the straddling pair still comes from the old state and that the following cycle reflects the new one. Odd counts and a start address near the top of the array push the sequencer into its half-pair tail and its address wrap.

// File: rtl/spad_pkg.sv
package spad_pkg;

  // Operand classes held by the buffer; value is the slice index on the ports.
  typedef enum int {
    CLS_INPUT  = 0,
    CLS_WEIGHT = 1,
    CLS_BIAS   = 2,
    CLS_LEAK   = 3,
    CLS_ACT    = 4
  } spad_class_e;

  localparam int SPAD_CLASSES = 5;

endpackage

// File: rtl/spad_burst_seq.sv
module spad_burst_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   len,
  output logic              issue_a,
  output logic              issue_b,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic              active
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ptr    <= '0;
      left   <= '0;
    end else if (go) begin
      active <= (len != '0);
      ptr    <= base;
      left   <= len;
    end else if (active) begin
      ptr <= ptr + ADDR_W'(2);
      if (left <= TWO) begin
        active <= 1'b0;
        left   <= '0;
      end else begin
        left <= left - TWO;
      end
    end
  end

  assign issue_a = active;
  assign issue_b = active && (left >= TWO);
  assign addr_a  = ptr;
  assign addr_b  = ptr + ADDR_W'(1);

  assert_go_arms_R3: assert property (@(posedge clk) disable iff (rst)
    (go && len != '0) |=> active);
  assert_zero_cancels_R7: assert property (@(posedge clk) disable iff (rst)
    (go && len == '0) |=> !active);
  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !go && left <= TWO) |=> !active);
  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> !active);

endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wa_b,
  input  logic [DATA_W-1:0] wd_b,
  input  logic              re_a,
  input  logic [ADDR_W-1:0] ra_a,
  input  logic              re_b,
  input  logic [ADDR_W-1:0] ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic              rv_a,
  output logic [DATA_W-1:0] rd_b,
  output logic              rv_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Lane B is written last so it wins on an equal address.
  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  // Registered read: sees the array before this edge's writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a <= '0;
      rd_b <= '0;
      rv_a <= 1'b0;
      rv_b <= 1'b0;
    end else begin
      rv_a <= re_a;
      rv_b <= re_b;
      rd_a <= re_a ? mem[ra_a] : '0;
      rd_b <= re_b ? mem[ra_b] : '0;
    end
  end

  assert_issue_delivers_R5: assert property (@(posedge clk) disable iff (rst)
    re_a |=> rv_a);
  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !re_a |=> !rv_a);
  assert_b_needs_a_R4: assert property (@(posedge clk) disable iff (rst)
    rv_b |-> rv_a);
  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!rv_a && !rv_b && rd_a == '0 && rd_b == '0));

endmodule

// File: rtl/spad_class_slice.sv
module spad_class_slice #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wa_b,
  input  logic [DATA_W-1:0] wd_b,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   len,
  output logic [DATA_W-1:0] rd_a,
  output logic              rv_a,
  output logic [DATA_W-1:0] rd_b,
  output logic              rv_b,
  output logic              busy
);

  logic              iss_a, iss_b;
  logic [ADDR_W-1:0] ra_a, ra_b;

  spad_burst_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst(rst), .go(go), .base(base), .len(len),
    .issue_a(iss_a), .issue_b(iss_b), .addr_a(ra_a), .addr_b(ra_b),
    .active(busy)
  );

  spad_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
    .clk(clk), .rst(rst),
    .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a),
    .we_b(we_b), .wa_b(wa_b), .wd_b(wd_b),
    .re_a(iss_a), .ra_a(ra_a), .re_b(iss_b), .ra_b(ra_b),
    .rd_a(rd_a), .rv_a(rv_a), .rd_b(rd_b), .rv_b(rv_b)
  );

endmodule

// File: rtl/spad_burst_buffer.sv
module spad_burst_buffer
  import spad_pkg::*;
#(
  parameter int N_CLASS = SPAD_CLASSES,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CLASS-1:0]          wr_en_a,
  input  logic [N_CLASS*ADDR_W-1:0]   wr_addr_a,
  input  logic [N_CLASS*DATA_W-1:0]   wr_data_a,
  input  logic [N_CLASS-1:0]          wr_en_b,
  input  logic [N_CLASS*ADDR_W-1:0]   wr_addr_b,
  input  logic [N_CLASS*DATA_W-1:0]   wr_data_b,
  input  logic [N_CLASS-1:0]          rd_go,
  input  logic [N_CLASS*ADDR_W-1:0]   rd_base,
  input  logic [N_CLASS*(ADDR_W+1)-1:0] rd_len,
  output logic [N_CLASS*DATA_W-1:0]   rd_data_a,
  output logic [N_CLASS-1:0]          rd_valid_a,
  output logic [N_CLASS*DATA_W-1:0]   rd_data_b,
  output logic [N_CLASS-1:0]          rd_valid_b,
  output logic [N_CLASS-1:0]          busy
);

  localparam int CNT_W = ADDR_W + 1;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    spad_class_slice #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_slice (
      .clk (clk),
      .rst (rst),
      .we_a(wr_en_a[c]),
      .wa_a(wr_addr_a[c*ADDR_W +: ADDR_W]),
      .wd_a(wr_data_a[c*DATA_W +: DATA_W]),
      .we_b(wr_en_b[c]),
      .wa_b(wr_addr_b[c*ADDR_W +: ADDR_W]),
      .wd_b(wr_data_b[c*DATA_W +: DATA_W]),
      .go  (rd_go[c]),
      .base(rd_base[c*ADDR_W +: ADDR_W]),
      .len (rd_len[c*CNT_W +: CNT_W]),
      .rd_a(rd_data_a[c*DATA_W +: DATA_W]),
      .rv_a(rd_valid_a[c]),
      .rd_b(rd_data_b[c*DATA_W +: DATA_W]),
      .rv_b(rd_valid_b[c]),
      .busy(busy[c])
    );
  end

endmodule

// File: tb/test_spad_burst_buffer.sv
module test_spad_burst_buffer;

  localparam int NC = 5;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int CW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    wr_en_a = '0, wr_en_b = '0, rd_go = '0;
  logic [NC*AW-1:0] wr_addr_a = '0, wr_addr_b = '0, rd_base = '0;
  logic [NC*DW-1:0] wr_data_a = '0, wr_data_b = '0;
  logic [NC*CW-1:0] rd_len = '0;
  logic [NC*DW-1:0] rd_data_a, rd_data_b;
  logic [NC-1:0]    rd_valid_a, rd_valid_b, busy;

  logic [DW-1:0] model [NC][DEPTH];
  int applied = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  spad_burst_buffer #(.N_CLASS(NC), .DATA_W(DW), .ADDR_W(AW)) i_spad_burst_buffer (
    .clk(clk), .rst(rst),
    .wr_en_a(wr_en_a), .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
    .wr_en_b(wr_en_b), .wr_addr_b(wr_addr_b), .wr_data_b(wr_data_b),
    .rd_go(rd_go), .rd_base(rd_base), .rd_len(rd_len),
    .rd_data_a(rd_data_a), .rd_valid_a(rd_valid_a),
    .rd_data_b(rd_data_b), .rd_valid_b(rd_valid_b), .busy(busy)
  );

  function automatic logic [DW-1:0] pat(int c, int a);
    return DW'((c + 1) * 4096) ^ DW'(a * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(int c, int base, int len);
    rd_go[c] = 1'b1;
    rd_base[c*AW +: AW] = AW'(base);
    rd_len[c*CW +: CW] = CW'(len);
  endtask

  task automatic cmd_off(int c);
    rd_go[c] = 1'b0;
  endtask

  // Check one delivered pair of class c (called just after a falling edge).
  task automatic chk_pair(int c, int aa, bit bv, string req);
    chk(rd_valid_a[c] == 1'b1, req, rd_valid_a[c], 1);
    chk(rd_data_a[c*DW +: DW] == model[c][aa % DEPTH], req,
        rd_data_a[c*DW +: DW], model[c][aa % DEPTH]);
    chk(rd_valid_b[c] == bv, req, rd_valid_b[c], bv);
    chk(rd_data_b[c*DW +: DW] == (bv ? model[c][(aa + 1) % DEPTH] : '0), req,
        rd_data_b[c*DW +: DW], bv ? model[c][(aa + 1) % DEPTH] : 0);
  endtask

  // Full burst from idle, checking busy and every pair.
  task automatic run_burst(int c, int base, int len, string req);
    int pairs = (len + 1) / 2;
    cmd(c, base, len);
    @(negedge clk);
    cmd_off(c);
    chk(busy[c] == 1'b1, req, busy[c], 1);
    for (int k = 0; k < pairs; k++) begin
      @(negedge clk);
      chk_pair(c, base + 2 * k, (2 * k + 1) < len, req);
      chk(busy[c] == (k < pairs - 1), req, busy[c], k < pairs - 1);
    end
    @(negedge clk);
    chk(rd_valid_a[c] == 1'b0 && rd_valid_b[c] == 1'b0, req, rd_valid_a[c], 0);
  endtask

  task automatic t_reset;
    chk(rd_valid_a == '0 && rd_valid_b == '0, "R11 valid", rd_valid_a, 0);
    chk(busy == '0, "R11 busy", busy, 0);
    chk(rd_data_a == '0 && rd_data_b == '0, "R11 data", rd_data_a[15:0], 0);
  endtask

  // R1/R10: every class filled two locations per cycle with its own pattern.
  task automatic t_fill;
    for (int a = 0; a < DEPTH; a += 2) begin
      for (int c = 0; c < NC; c++) begin
        wr_en_a[c] = 1'b1; wr_addr_a[c*AW +: AW] = AW'(a);
        wr_data_a[c*DW +: DW] = pat(c, a);
        wr_en_b[c] = 1'b1; wr_addr_b[c*AW +: AW] = AW'(a + 1);
        wr_data_b[c*DW +: DW] = pat(c, a + 1);
        model[c][a] = pat(c, a);
        model[c][a + 1] = pat(c, a + 1);
      end
      @(negedge clk);
    end
    wr_en_a = '0; wr_en_b = '0;
    chk(busy == '0 && rd_valid_a == '0, "R10 writes leave reads idle", busy, 0);
    for (int c = 0; c < NC; c++) run_burst(c, 16, 4, "R1 R10 class readback");
  endtask

  task automatic t_even;  run_burst(0, 4, 8, "R3 R5 even burst"); endtask
  task automatic t_odd;   run_burst(1, 7, 5, "R4 odd burst tail"); endtask
  task automatic t_single; run_burst(2, 33, 1, "R4 single location"); endtask
  task automatic t_wrap;  run_burst(3, 62, 5, "R9 address wrap"); endtask
  task automatic t_full;  run_burst(4, 0, DEPTH, "R3 full depth"); endtask

  task automatic t_same_addr;
    wr_en_a[2] = 1'b1; wr_addr_a[2*AW +: AW] = AW'(20); wr_data_a[2*DW +: DW] = 16'hAAAA;
    wr_en_b[2] = 1'b1; wr_addr_b[2*AW +: AW] = AW'(20); wr_data_b[2*DW +: DW] = 16'h5555;
    @(negedge clk);
    wr_en_a = '0; wr_en_b = '0;
    model[2][20] = 16'h5555;
    run_burst(2, 20, 2, "R2 lane B wins");
  endtask

  task automatic t_read_old;
    logic [DW-1:0] old = model[3][10];
    cmd(3, 10, 4);
    @(negedge clk);
    cmd_off(3);
    wr_en_a[3] = 1'b1; wr_addr_a[3*AW +: AW] = AW'(10); wr_data_a[3*DW +: DW] = 16'hBEEF;
    @(negedge clk);                 // pair 0 fetched on the write edge
    wr_en_a = '0;
    chk(rd_data_a[3*DW +: DW] == old, "R8 read returns old", rd_data_a[3*DW +: DW], old);
    model[3][10] = 16'hBEEF;
    @(negedge clk);
    chk_pair(3, 12, 1'b1, "R8 burst continues");
    @(negedge clk);
    run_burst(3, 10, 2, "R8 new value later");
  endtask

  task automatic t_replace;
    cmd(1, 0, 10);
    @(negedge clk);
    cmd_off(1);
    @(negedge clk);
    chk_pair(1, 0, 1'b1, "R6 first old pair");
    cmd(1, 40, 3);
    @(negedge clk);
    cmd_off(1);
    chk_pair(1, 2, 1'b1, "R6 scheduled old pair kept");
    chk(busy[1] == 1'b1, "R6 busy", busy[1], 1);
    @(negedge clk);
    chk_pair(1, 40, 1'b1, "R6 new burst no gap");
    @(negedge clk);
    chk_pair(1, 42, 1'b0, "R6 new burst tail");
    chk(busy[1] == 1'b0, "R6 busy end", busy[1], 0);
    @(negedge clk);
    chk(rd_valid_a[1] == 1'b0, "R6 idle after", rd_valid_a[1], 0);
  endtask

  task automatic t_cancel;
    cmd(0, 0, 8);
    @(negedge clk);
    cmd_off(0);
    @(negedge clk);
    chk_pair(0, 0, 1'b1, "R7 pair before cancel");
    cmd(0, 30, 0);
    @(negedge clk);
    cmd_off(0);
    chk_pair(0, 2, 1'b1, "R7 scheduled pair");
    chk(busy[0] == 1'b0, "R7 busy drops", busy[0], 0);
    @(negedge clk);
    chk(rd_valid_a[0] == 1'b0 && rd_valid_b[0] == 1'b0, "R7 no more data", rd_valid_a[0], 0);
  endtask

  task automatic t_parallel;
    cmd(0, 50, 4);
    cmd(4, 9, 3);
    @(negedge clk);
    cmd_off(0); cmd_off(4);
    chk(busy == 5'b10001, "R10 only commanded busy", busy, 5'b10001);
    @(negedge clk);
    chk_pair(0, 50, 1'b1, "R10 class0 pair");
    chk_pair(4, 9, 1'b1, "R10 class4 pair");
    chk(rd_valid_a[3:1] == '0, "R10 others idle", rd_valid_a[3:1], 0);
    @(negedge clk);
    chk_pair(0, 52, 1'b1, "R10 class0 pair");
    chk_pair(4, 11, 1'b0, "R10 class4 tail");
    @(negedge clk);
    chk(rd_valid_a == '0, "R10 all idle", rd_valid_a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_fill();
    t_even();
    t_odd();
    t_single();
    t_wrap();
    t_full();
    t_same_addr();
    t_read_old();
    t_replace();
    t_cancel();
    t_parallel();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule